// File: doc/BRIEF.md
# Burst Copy Stream Engine

The block is a register-mapped copy engine that moves one 32-byte line through four 64-bit staging words. Software fills the staging words either with direct register writes or by writing a source address, which makes the engine read four consecutive 64-bit words from memory. Writing a destination address makes the engine store the four staging words to memory. A register write is the only trigger; there is no start bit.

The register side is a single-cycle request port that carries a 12-bit window offset, a width flag and two 32-bit data lanes. The high lane is the primary lane and the low lane is the secondary lane. During a burst the engine raises `busy` and accepts no register request. The requester holds its request until `busy` is low, and the access takes effect in that cycle. The memory side is a 64-bit master that has one request outstanding at a time. It holds `memReq` with a stable address, direction and write data until `memAck`.

Top module: `burst_copy_engine`

## Requirements
- R1: A 64-bit write (`regWide`=1) to offset 0x000, 0x008, 0x010 or 0x018 loads staging word 0, 1, 2 or 3 with {`regWdataHi`,`regWdataLo`}.
- R2: A 64-bit write to offset 0x100 starts a fill. Four reads are issued at `regWdataLo`+0, +8, +16 and +24, in that order, and returning beat k loads staging word k.
- R3: A 64-bit write to offset 0x200 starts a drain. Four writes are issued at `regWdataLo`+0, +8, +16 and +24, and beat k carries staging word k.
- R4: Offset 0xA00 reads and writes the full 64-bit control word. A 32-bit access (`regWide`=0) at 0xA04 reads or writes only the low half, through the primary lane. A write at 0xA04 leaves the high half unchanged.
- R5: The error word at 0xE00 resets to the parameter `ERR_INIT` and is readable as 64 bits. A 64-bit write clears each bit that is 1 in the written data and leaves the other bits unchanged.
- R6: The port word at 0xF00 reads and writes as 64 bits.
- R7: A 64-bit read returns bits 63:32 on `regRdataHi` and bits 31:0 on `regRdataLo`. A 32-bit read returns its word on `regRdataHi` and zero on `regRdataLo`. A read of an unmapped offset, or a read of the wrong width, returns zero on both lanes.
- R8: A write of the wrong width or to an unmapped offset changes no register and starts no burst.
- R9: `busy` rises in the cycle after a fill or drain trigger and falls in the cycle after the fourth acknowledge. While `busy` is high, register requests are not accepted.
- R10: Only one memory request is outstanding at a time. `memAddr`, `memWrite` and `memWdata` stay stable until `memAck`, beats are issued in ascending address order, and `memReq` is low whenever `busy` is low.
- R11: After reset `busy` and `memReq` are low, the control and port words read as zero, and the error word reads as `ERR_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regReq | input | 1 | Register access request, held until accepted |
| regWrite | input | 1 | 1 = write, 0 = read |
| regWide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| regOffset | input | 12 | Byte offset within the engine window |
| regWdataHi | input | 32 | Primary write lane (upper word, or the 32-bit word) |
| regWdataLo | input | 32 | Secondary write lane (lower word) |
| regRdataHi | output | 32 | Primary read lane |
| regRdataLo | output | 32 | Secondary read lane |
| busy | output | 1 | Burst in progress; register requests stall |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | 32 | Beat byte address |
| memWdata | output | 64 | Write beat data |
| memAck | input | 1 | Memory acknowledge of the current beat |
| memRdata | input | 64 | Read beat data, valid with `memAck` |

## Verification
Drains run first with directly written staging words and then with words loaded by fills. A fill followed by a drain to another area shows whether beat k of the fill reaches staging word k. Fills use an aligned base and an unaligned base, and the memory acknowledges either at once or every third cycle. These separate ascending address stepping and hold-until-acknowledge from accidental timing. Wrong-width and unmapped writes are each followed by a drain or a read that would expose a change. A staging write issued during a drain checks that the stall keeps the old data on the bus.

// File: rtl/copy_engine_pkg.sv
package copy_engine_pkg;

  localparam int OFF_W       = 12;
  localparam int BEATS       = 4;
  localparam int BEAT_BYTES  = 8;
  localparam int BEAT_IDX_W  = $clog2(BEATS);
  localparam int BEAT_SHIFT  = $clog2(BEAT_BYTES);
  localparam int STAGE_SPAN  = BEATS * BEAT_BYTES;

  localparam logic [OFF_W-1:0] OFF_STAGE   = 12'h000;
  localparam logic [OFF_W-1:0] OFF_SRC     = 12'h100;
  localparam logic [OFF_W-1:0] OFF_DST     = 12'h200;
  localparam logic [OFF_W-1:0] OFF_CTRL    = 12'hA00;
  localparam logic [OFF_W-1:0] OFF_CTRL_LO = 12'hA04;
  localparam logic [OFF_W-1:0] OFF_ERR     = 12'hE00;
  localparam logic [OFF_W-1:0] OFF_PORT    = 12'hF00;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_FILL,
    ENG_DRAIN
  } engState_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_CTRL_LO,
    RD_ERR,
    RD_PORT
  } rdSel_e;

  typedef struct packed {
    logic                  stageWr;
    logic [BEAT_IDX_W-1:0] stageIdx;
    logic                  srcWr;
    logic                  dstWr;
    logic                  ctrlWr;
    logic                  ctrlLoWr;
    logic                  errClr;
    logic                  portWr;
    logic                  beatLoad;
    logic                  beatIsWrite;
    logic [BEAT_IDX_W-1:0] beatIdx;
    rdSel_e                rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/copy_ctrl.sv
module copy_ctrl
  import copy_engine_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regReq,
  input  logic                   regWrite,
  input  logic                   regWide,
  input  logic [OFF_W-1:0]       regOffset,
  input  logic                   memAck,
  output ctrlStrobe_t            strobe,
  output logic                   busy,
  output logic                   memReq,
  output logic                   memWrite
);

  localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(BEATS - 1);

  engState_e             state;
  logic [BEAT_IDX_W-1:0] beatCnt;

  logic accept;
  logic wrWide;
  logic rdAcc;
  logic stageHit;

  assign accept   = regReq && (state == ENG_IDLE);
  assign wrWide   = accept && regWrite && regWide;
  assign rdAcc    = accept && !regWrite;
  assign stageHit = (regOffset[OFF_W-1:BEAT_IDX_W+BEAT_SHIFT] == '0) &&
                    (regOffset[BEAT_SHIFT-1:0] == '0);

  always_comb begin
    strobe             = '0;
    strobe.rdSel       = RD_NONE;
    strobe.stageIdx    = regOffset[BEAT_IDX_W+BEAT_SHIFT-1:BEAT_SHIFT];
    strobe.stageWr     = wrWide && stageHit;
    strobe.srcWr       = wrWide && (regOffset == OFF_SRC);
    strobe.dstWr       = wrWide && (regOffset == OFF_DST);
    strobe.ctrlWr      = wrWide && (regOffset == OFF_CTRL);
    strobe.ctrlLoWr    = accept && regWrite && !regWide && (regOffset == OFF_CTRL_LO);
    strobe.errClr      = wrWide && (regOffset == OFF_ERR);
    strobe.portWr      = wrWide && (regOffset == OFF_PORT);
    strobe.beatLoad    = (state == ENG_FILL) && memAck;
    strobe.beatIsWrite = (state == ENG_DRAIN);
    strobe.beatIdx     = beatCnt;
    if (rdAcc) begin
      if (regWide && regOffset == OFF_CTRL)         strobe.rdSel = RD_CTRL;
      else if (!regWide && regOffset == OFF_CTRL_LO) strobe.rdSel = RD_CTRL_LO;
      else if (regWide && regOffset == OFF_ERR)     strobe.rdSel = RD_ERR;
      else if (regWide && regOffset == OFF_PORT)    strobe.rdSel = RD_PORT;
      else                                          strobe.rdSel = RD_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ENG_IDLE;
      beatCnt <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          beatCnt <= '0;
          if (strobe.srcWr)      state <= ENG_FILL;
          else if (strobe.dstWr) state <= ENG_DRAIN;
        end
        ENG_FILL, ENG_DRAIN: begin
          if (memAck) begin
            if (beatCnt == LAST_BEAT) begin
              state   <= ENG_IDLE;
              beatCnt <= '0;
            end else begin
              beatCnt <= beatCnt + 1'b1;
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy     = (state != ENG_IDLE);
  assign memReq   = busy;
  assign memWrite = (state == ENG_DRAIN);

endmodule

// File: rtl/copy_datapath.sv
module copy_datapath
  import copy_engine_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 64,
  parameter logic [63:0] ERR_INIT = 64'h0
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W/2-1:0] regWdataHi,
  input  logic [DATA_W/2-1:0] regWdataLo,
  output logic [DATA_W/2-1:0] regRdataHi,
  output logic [DATA_W/2-1:0] regRdataLo,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] stage [BEATS];
  logic [DATA_W-1:0] srcReg;
  logic [DATA_W-1:0] dstReg;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] errReg;
  logic [DATA_W-1:0] portReg;

  assign wdata = {regWdataHi, regWdataLo};

  for (genvar g = 0; g < BEATS; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[g] <= '0;
      end else if (strobe.stageWr && strobe.stageIdx == BEAT_IDX_W'(g)) begin
        stage[g] <= wdata;
      end else if (strobe.beatLoad && strobe.beatIdx == BEAT_IDX_W'(g)) begin
        stage[g] <= memRdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg  <= '0;
      dstReg  <= '0;
      ctrlReg <= '0;
      errReg  <= DATA_W'(ERR_INIT);
      portReg <= '0;
    end else begin
      if (strobe.srcWr)    srcReg  <= wdata;
      if (strobe.dstWr)    dstReg  <= wdata;
      if (strobe.ctrlWr)   ctrlReg <= wdata;
      if (strobe.ctrlLoWr) ctrlReg <= {ctrlReg[DATA_W-1:HALF_W], regWdataHi};
      if (strobe.errClr)   errReg  <= errReg & ~wdata;
      if (strobe.portWr)   portReg <= wdata;
    end
  end

  logic [ADDR_W-1:0] beatBase;
  logic [ADDR_W-1:0] beatOffset;

  assign beatBase   = strobe.beatIsWrite ? dstReg[ADDR_W-1:0] : srcReg[ADDR_W-1:0];
  assign beatOffset = ADDR_W'(strobe.beatIdx) << BEAT_SHIFT;
  assign memAddr    = beatBase + beatOffset;
  assign memWdata   = stage[strobe.beatIdx];

  always_comb begin
    regRdataHi = '0;
    regRdataLo = '0;
    unique case (strobe.rdSel)
      RD_CTRL:    {regRdataHi, regRdataLo} = ctrlReg;
      RD_CTRL_LO: regRdataHi = ctrlReg[HALF_W-1:0];
      RD_ERR:     {regRdataHi, regRdataLo} = errReg;
      RD_PORT:    {regRdataHi, regRdataLo} = portReg;
      default:    ;
    endcase
  end

endmodule

// File: rtl/burst_copy_engine.sv
module burst_copy_engine
  import copy_engine_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 64,
  parameter logic [63:0] ERR_INIT = 64'hC3A5_0000_0000_5A3C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regReq,
  input  logic                regWrite,
  input  logic                regWide,
  input  logic [OFF_W-1:0]    regOffset,
  input  logic [DATA_W/2-1:0] regWdataHi,
  input  logic [DATA_W/2-1:0] regWdataLo,
  output logic [DATA_W/2-1:0] regRdataHi,
  output logic [DATA_W/2-1:0] regRdataLo,
  output logic                busy,
  output logic                memReq,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic                memAck,
  input  logic [DATA_W-1:0]   memRdata
);

  ctrlStrobe_t strobe;

  copy_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regReq    (regReq),
    .regWrite  (regWrite),
    .regWide   (regWide),
    .regOffset (regOffset),
    .memAck    (memAck),
    .strobe    (strobe),
    .busy      (busy),
    .memReq    (memReq),
    .memWrite  (memWrite)
  );

  copy_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ERR_INIT (ERR_INIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWdataHi (regWdataHi),
    .regWdataLo (regWdataLo),
    .regRdataHi (regRdataHi),
    .regRdataLo (regRdataLo),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: rtl/burst_copy_engine_chk.sv
module burst_copy_engine_chk
  import copy_engine_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                regReq,
  input logic                regWrite,
  input logic                regWide,
  input logic [OFF_W-1:0]    regOffset,
  input logic [DATA_W/2-1:0] regWdataLo,
  input logic [DATA_W/2-1:0] regRdataHi,
  input logic [DATA_W/2-1:0] regRdataLo,
  input logic                busy,
  input logic                memReq,
  input logic                memWrite,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [DATA_W-1:0]   memWdata,
  input logic                memAck
);

  logic [BEAT_IDX_W-1:0] ackCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ackCnt <= '0;
    else if (!memReq)        ackCnt <= '0;
    else if (memAck)         ackCnt <= ackCnt + 1'b1;
  end

  logic accWr;
  assign accWr = regReq && !busy && regWrite;

  // R2
  src_fill_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    accWr && regWide && regOffset == OFF_SRC |=>
      busy && memReq && !memWrite && memAddr == ADDR_W'($past(regWdataLo)));

  // R3
  dst_drain_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    accWr && regWide && regOffset == OFF_DST |=>
      busy && memReq && memWrite && memAddr == ADDR_W'($past(regWdataLo)));

  // R8
  narrow_src_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    accWr && !regWide && (regOffset == OFF_SRC || regOffset == OFF_DST) |=> !busy);

  // R10
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=>
      memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata));

  // R10
  ascending_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && ackCnt != BEAT_IDX_W'(BEATS - 1) |=>
      memReq && memAddr == $past(memAddr) + ADDR_W'(BEAT_BYTES));

  // R9
  last_ack_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && ackCnt == BEAT_IDX_W'(BEATS - 1) |=> !busy && !memReq);

  // R10
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  // R7
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !busy && !regWrite && regOffset == OFF_SRC |->
      regRdataHi == '0 && regRdataLo == '0);

endmodule

bind burst_copy_engine burst_copy_engine_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regReq     (regReq),
  .regWrite   (regWrite),
  .regWide    (regWide),
  .regOffset  (regOffset),
  .regWdataLo (regWdataLo),
  .regRdataHi (regRdataHi),
  .regRdataLo (regRdataLo),
  .busy       (busy),
  .memReq     (memReq),
  .memWrite   (memWrite),
  .memAddr    (memAddr),
  .memWdata   (memWdata),
  .memAck     (memAck)
);

// File: tb/tb_burst_copy_engine.sv
module tb_burst_copy_engine;

  localparam logic [63:0] ERR_RST = 64'hC3A5_0000_0000_5A3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regReq = 1'b0;
  logic        regWrite = 1'b0;
  logic        regWide = 1'b0;
  logic [11:0] regOffset = '0;
  logic [31:0] regWdataHi = '0;
  logic [31:0] regWdataLo = '0;
  logic [31:0] regRdataHi;
  logic [31:0] regRdataLo;
  logic        busy;
  logic        memReq;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [63:0] memWdata;
  logic        memAck;
  logic [63:0] memRdata;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  burst_copy_engine #(.ERR_INIT(ERR_RST)) dut (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWrite(regWrite),
    .regWide(regWide), .regOffset(regOffset), .regWdataHi(regWdataHi),
    .regWdataLo(regWdataLo), .regRdataHi(regRdataHi), .regRdataLo(regRdataLo),
    .busy(busy), .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  // ---------------- memory responder ----------------
  logic [63:0] mem [int unsigned];
  logic        ackSlow = 1'b0;
  int          cycleCnt = 0;

  function automatic logic [63:0] memVal(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a, ~a};
  endfunction

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  assign memAck = memReq && (!ackSlow || (cycleCnt % 3 == 0));

  always @* memRdata = (memReq && !memWrite) ? memVal(memAddr) : 64'h0;

  always @(posedge clk) if (rstN && memReq && memAck && memWrite) mem[memAddr] = memWdata;

  // ---------------- reference model ----------------
  typedef struct { logic [31:0] addr; bit wr; int idx; } beat_t;
  beat_t       q[$];
  logic [63:0] mStage [4];
  logic [63:0] mCtrl, mErr, mPort;
  bit          mWasBusy;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelWrite();
    logic [63:0] wd;
    wd = {regWdataHi, regWdataLo};
    if (regWide) begin
      if (regOffset[11:5] == 0 && regOffset[2:0] == 0) mStage[regOffset[4:3]] = wd;
      else if (regOffset == 12'h100) for (int k = 0; k < 4; k++) q.push_back('{regWdataLo + 32'(8 * k), 1'b0, k});
      else if (regOffset == 12'h200) for (int k = 0; k < 4; k++) q.push_back('{regWdataLo + 32'(8 * k), 1'b1, k});
      else if (regOffset == 12'hA00) mCtrl = wd;
      else if (regOffset == 12'hE00) mErr = mErr & ~wd;
      else if (regOffset == 12'hF00) mPort = wd;
    end else if (regOffset == 12'hA04) begin
      mCtrl[31:0] = regWdataHi;
    end
  endtask

  function automatic logic [63:0] expRead();
    if (regWide && regOffset == 12'hA00) return mCtrl;
    if (!regWide && regOffset == 12'hA04) return {mCtrl[31:0], 32'h0};
    if (regWide && regOffset == 12'hE00) return mErr;
    if (regWide && regOffset == 12'hF00) return mPort;
    return 64'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      for (int k = 0; k < 4; k++) mStage[k] = 64'h0;
      mCtrl = 64'h0; mErr = ERR_RST; mPort = 64'h0;
    end else begin
      mWasBusy = (q.size() != 0);
      if (q.size() != 0 && memAck) begin
        if (!q[0].wr) mStage[q[0].idx] = memVal(q[0].addr);
        void'(q.pop_front());
      end
      if (regReq && regWrite && !mWasBusy) modelWrite();
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(busy == (q.size() != 0), "R9 busy", 64'(busy), 64'(q.size() != 0));
      check(memReq == (q.size() != 0), "R10 memReq", 64'(memReq), 64'(q.size() != 0));
      if (q.size() != 0) begin
        check(memAddr == q[0].addr, q[0].wr ? "R3 drain address" : "R2 fill address", 64'(memAddr), 64'(q[0].addr));
        check(memWrite == q[0].wr, "R10 direction", 64'(memWrite), 64'(q[0].wr));
        if (q[0].wr) check(memWdata == mStage[q[0].idx], "R3 drain data", memWdata, mStage[q[0].idx]);
      end
      if (regReq && !regWrite && q.size() == 0)
        check({regRdataHi, regRdataLo} == expRead(), "R7 read lanes", {regRdataHi, regRdataLo}, expRead());
    end
  end

  // ---------------- stimulus ----------------
  logic [63:0] lastRd;

  task automatic regAccess(input bit wr, input logic [11:0] off, input bit wide, input logic [63:0] d);
    bit acc;
    @(posedge clk); #1;
    regReq = 1'b1; regWrite = wr; regOffset = off; regWide = wide;
    regWdataHi = d[63:32]; regWdataLo = d[31:0];
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = !busy;
      if (acc) lastRd = {regRdataHi, regRdataLo};
      @(posedge clk);
    end
    #1 regReq = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  logic [63:0] pat [4];

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy == 1'b0 && memReq == 1'b0, "R11 idle after reset", {busy, memReq}, 64'h0);
    regAccess(0, 12'hA00, 1, 0); check(lastRd == 64'h0, "R11 control reset", lastRd, 64'h0);
    regAccess(0, 12'hF00, 1, 0); check(lastRd == 64'h0, "R11 port reset", lastRd, 64'h0);
    regAccess(0, 12'hE00, 1, 0); check(lastRd == ERR_RST, "R11 error reset", lastRd, ERR_RST);

    // R1 direct staging then drain (R3)
    for (int k = 0; k < 4; k++) begin
      pat[k] = {32'h1111_0000 + 32'(k), 32'hA0A0_0000 + 32'(k * 7)};
      regAccess(1, 12'(8 * k), 1, pat[k]);
    end
    regAccess(1, 12'h200, 1, 64'h0000_0000_0000_1000);
    waitIdle();
    for (int k = 0; k < 4; k++)
      check(memVal(32'h1000 + 32'(8 * k)) == pat[k], "R1 staging word in memory", memVal(32'h1000 + 32'(8 * k)), pat[k]);

    // R2 fill with slow acks, then drain elsewhere
    ackSlow = 1'b1;
    regAccess(1, 12'h100, 1, 64'hDEAD_BEEF_0000_2000);
    waitIdle();
    regAccess(1, 12'h200, 1, 64'h0000_0000_0000_3000);
    waitIdle();
    for (int k = 0; k < 4; k++)
      check(memVal(32'h3000 + 32'(8 * k)) == memVal(32'h2000 + 32'(8 * k)), "R2 fill order", memVal(32'h3000 + 32'(8 * k)), memVal(32'h2000 + 32'(8 * k)));

    // R2 unaligned base, fast acks
    ackSlow = 1'b0;
    regAccess(1, 12'h100, 1, 64'h0000_0000_0000_4004);
    waitIdle();
    // R8 wrong-width and unmapped writes must not disturb staging or start bursts
    regAccess(1, 12'h008, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    regAccess(1, 12'h100, 0, 64'h0000_0000_0000_7000);
    check(busy == 1'b0, "R8 narrow source write no burst", 64'(busy), 64'h0);
    regAccess(1, 12'h300, 1, 64'h0000_0000_0000_7000);
    check(busy == 1'b0, "R8 unmapped write no burst", 64'(busy), 64'h0);
    regAccess(1, 12'h200, 1, 64'h0000_0000_0000_6000);
    waitIdle();
    for (int k = 0; k < 4; k++)
      check(memVal(32'h6000 + 32'(8 * k)) == memVal(32'h4004 + 32'(8 * k)), "R8 staging unchanged", memVal(32'h6000 + 32'(8 * k)), memVal(32'h4004 + 32'(8 * k)));

    // R4 control word
    regAccess(1, 12'hA00, 1, 64'h1234_5678_9ABC_DEF0);
    regAccess(0, 12'hA00, 1, 0); check(lastRd == 64'h1234_5678_9ABC_DEF0, "R4 control 64-bit", lastRd, 64'h1234_5678_9ABC_DEF0);
    regAccess(1, 12'hA04, 0, 64'h0BAD_F00D_5555_5555);
    regAccess(0, 12'hA00, 1, 0); check(lastRd == 64'h1234_5678_0BAD_F00D, "R4 low-half write", lastRd, 64'h1234_5678_0BAD_F00D);
    regAccess(0, 12'hA04, 0, 0); check(lastRd == 64'h0BAD_F00D_0000_0000, "R7 32-bit read lane", lastRd, 64'h0BAD_F00D_0000_0000);
    regAccess(0, 12'hA04, 1, 0); check(lastRd == 64'h0, "R7 wrong-width read", lastRd, 64'h0);
    regAccess(1, 12'hA00, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    regAccess(0, 12'hA00, 1, 0); check(lastRd == 64'h1234_5678_0BAD_F00D, "R8 narrow control write", lastRd, 64'h1234_5678_0BAD_F00D);

    // R5 error clear
    regAccess(1, 12'hE00, 1, 64'h8021_0000_0000_1004);
    regAccess(0, 12'hE00, 1, 0); check(lastRd == (ERR_RST & ~64'h8021_0000_0000_1004), "R5 write-one-to-clear", lastRd, ERR_RST & ~64'h8021_0000_0000_1004);
    regAccess(1, 12'hE00, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    regAccess(0, 12'hE00, 1, 0); check(lastRd == (ERR_RST & ~64'h8021_0000_0000_1004), "R8 narrow error write", lastRd, ERR_RST & ~64'h8021_0000_0000_1004);

    // R6 port word
    regAccess(1, 12'hF00, 1, 64'hCAFE_0001_0002_0003);
    regAccess(0, 12'hF00, 1, 0); check(lastRd == 64'hCAFE_0001_0002_0003, "R6 port word", lastRd, 64'hCAFE_0001_0002_0003);

    // R9 stall: staging write issued during a drain waits until the drain completes
    ackSlow = 1'b1;
    regAccess(1, 12'h200, 1, 64'h0000_0000_0000_8000);
    regAccess(1, 12'h000, 1, 64'h7777_7777_8888_8888);
    check(busy == 1'b0, "R9 stalled access after burst", 64'(busy), 64'h0);
    check(memVal(32'h8000) == memVal(32'h4004), "R9 drain kept old data", memVal(32'h8000), memVal(32'h4004));
    ackSlow = 1'b0;
    regAccess(1, 12'h200, 1, 64'h0000_0000_0000_9000);
    waitIdle();
    check(memVal(32'h9000) == 64'h7777_7777_8888_8888, "R1 post-stall staging write", memVal(32'h9000), 64'h7777_7777_8888_8888);

    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule